// File: doc/BRIEF.md
# Address-Masked GPIO Register Block

This block is an eight-pin general-purpose I/O peripheral seen by software through a 4 KB register window on a simple single-cycle bus. The lowest kilobyte of the window is one data register seen through many addresses. Address bits [9:2] of each access act as a per-bit mask. A write changes only the selected data bits, and a read returns only the selected bits. Software can therefore update one pin without a read-modify-write sequence.

Above the data window sit a direction register and the interrupt controls. A build-time parameter chooses between two register sets. The plain set ends with the interrupt controls. The extended set adds a pull-enable register and an analog-mode register. Above the last register of the chosen set, the window is reserved up to offset 0xFCC. Reads there return zero, writes there are dropped, and an error pulse flags the access. The top twelve words hold read-only identification values.

Every bus access completes in the cycle it is presented. Register writes land on the next clock edge, so the pin outputs and the interrupt line follow one cycle later.

Top module: `gpio_regblock`

## Requirements
- R1: A read at a word offset below 0x400 returns a value whose bit i is zero when address bit 2+i is clear. Where the address bit is set, bit i comes from the data register if pin i is an output (direction bit 1) and from `gpio_in[i]` if pin i is an input.
- R2: A write at a word offset below 0x400 replaces data bit i with `bus_wdata[i]` only where address bit 2+i is set, and keeps every other data bit. `gpio_out` shows the data register.
- R3: Offset 0x400 holds the direction register, which keeps the low 8 bits of a write. `gpio_oe` shows it, and a 1 makes the pin an output.
- R4: After reset the data, direction, interrupt-mask, pull-enable and analog-mode registers read zero, and `gpio_out`, `gpio_oe`, `gpio_pull`, `gpio_ana` and `irq` are all low.
- R5: With EXTENDED=1, offset 0x510 holds a pull-enable register and offset 0x528 holds an analog-mode register. Each keeps the low 8 bits of a write and drives `gpio_pull` or `gpio_ana` respectively. With EXTENDED=0 both outputs stay zero.
- R6: The reserved region runs from 0x424 (EXTENDED=0) or 0x52C (EXTENDED=1) up to and including 0xFCC. A read there returns zero, a write there changes no register, and `bus_err` is high for that access.
- R7: Every other offset that names no register also raises `bus_err`, reads zero and changes nothing. This covers the gaps in the 0x404–0x524 range and writes to the read-only offsets 0x414, 0x418 and 0xFD0–0xFFC.
- R8: `bus_err` is high only in a cycle where `bus_sel` is high and the access is erroneous. It is low for every valid access and is never held past the access cycle.
- R9: A read at word offset 0xFD0 + 4·k (k = 0..11) returns 0x60 + k with EXTENDED=0, and 0x90 + k with EXTENDED=1.
- R10: A rising edge on `gpio_in[i]` while pin i is an input sets raw status bit i, which reads at 0x414. Offset 0x410 is the interrupt mask, and 0x418 reads raw AND mask. Writing 1s to 0x41C clears those raw bits, but a new edge in the same cycle wins over the clear. `irq` is high when any masked status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access present this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset in the 4 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle, zero otherwise |
| bus_err | output | 1 | Error pulse for an erroneous access |
| gpio_in | input | 8 | Pin input levels |
| gpio_out | output | 8 | Pin output levels |
| gpio_oe | output | 8 | Pin output enables |
| gpio_pull | output | 8 | Pull enables (extended set) |
| gpio_ana | output | 8 | Analog-mode selects (extended set) |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check the following on every cycle:
- an access inside the reserved range always raises the error;
- an erroneous read returns zero;
- an erroneous write leaves every register unchanged;
- a data write keeps the bits its address did not select;
- the error never appears without a select;
- no raw status bit is set for a pin that was an output.

Only the bench scenarios can show the values themselves. These are the masked read composition of pin levels and stored bits, the variant-dependent start of the reserved range, the identification values, and the interplay of edge capture, mask and write-one-to-clear on the interrupt line. The bench runs both variants side by side against a behavioural model on the same stimulus.

// File: rtl/gpio_regblock_pkg.sv
package gpio_regblock_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    typedef enum logic [3:0] {
        TGT_NONE,
        TGT_DATA,
        TGT_DIR,
        TGT_IMASK,
        TGT_RAW,
        TGT_MIS,
        TGT_ICLR,
        TGT_PULL,
        TGT_ANA,
        TGT_ID
    } tgt_e;

    localparam logic [ADDR_W-1:0] OFS_DIR         = 12'h400;
    localparam logic [ADDR_W-1:0] OFS_IMASK       = 12'h410;
    localparam logic [ADDR_W-1:0] OFS_RAW         = 12'h414;
    localparam logic [ADDR_W-1:0] OFS_MIS         = 12'h418;
    localparam logic [ADDR_W-1:0] OFS_ICLR        = 12'h41C;
    localparam logic [ADDR_W-1:0] OFS_PULL        = 12'h510;
    localparam logic [ADDR_W-1:0] OFS_ANA         = 12'h528;
    localparam logic [ADDR_W-1:0] RSV_LO_PLAIN    = 12'h424;
    localparam logic [ADDR_W-1:0] RSV_LO_EXT      = 12'h52C;
    localparam logic [ADDR_W-1:0] RSV_HI          = 12'hFCC;
    localparam logic [ADDR_W-1:0] OFS_ID_BASE     = 12'hFD0;

    function automatic logic [7:0] id_value(input logic ext, input logic [3:0] idx);
        return (ext ? 8'h90 : 8'h60) + {4'h0, idx};
    endfunction

endpackage

// File: rtl/gpio_regblock_decode.sv
module gpio_regblock_decode
    import gpio_regblock_pkg::*;
#(
    parameter bit EXTENDED = 1'b0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output tgt_e              tgt,
    output logic              bad
);
    localparam logic [ADDR_W-1:0] RSV_LO = EXTENDED ? RSV_LO_EXT : RSV_LO_PLAIN;

    logic [ADDR_W-1:0] word;
    logic              unused_lsb;

    assign word       = {addr[ADDR_W-1:2], 2'b00};
    assign unused_lsb = ^addr[1:0];

    always_comb begin
        tgt = TGT_NONE;
        if (word < OFS_DIR) begin
            tgt = TGT_DATA;
        end else if (word >= RSV_LO && word <= RSV_HI) begin
            tgt = TGT_NONE;
        end else if (word >= OFS_ID_BASE) begin
            tgt = TGT_ID;
        end else begin
            case (word)
                OFS_DIR:   tgt = TGT_DIR;
                OFS_IMASK: tgt = TGT_IMASK;
                OFS_RAW:   tgt = TGT_RAW;
                OFS_MIS:   tgt = TGT_MIS;
                OFS_ICLR:  tgt = TGT_ICLR;
                OFS_PULL:  tgt = EXTENDED ? TGT_PULL : TGT_NONE;
                OFS_ANA:   tgt = EXTENDED ? TGT_ANA : TGT_NONE;
                default:   tgt = TGT_NONE;
            endcase
        end
        bad = (tgt == TGT_NONE)
            || (wr && (tgt == TGT_RAW || tgt == TGT_MIS || tgt == TGT_ID));
    end

endmodule

// File: rtl/gpio_regblock_irq.sv
module gpio_regblock_irq #(
    parameter int PIN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PIN_W-1:0] pin_in,
    input  logic [PIN_W-1:0] dir,
    input  logic [PIN_W-1:0] mask,
    input  logic             clr_en,
    input  logic [PIN_W-1:0] clr_bits,
    output logic [PIN_W-1:0] raw,
    output logic             irq
);
    typedef struct packed {
        logic [PIN_W-1:0] raw;
        logic [PIN_W-1:0] prev;
    } irq_state_t;

    irq_state_t       st_d, st_q;
    logic [PIN_W-1:0] rise;

    always_comb begin
        st_d      = st_q;
        rise      = pin_in & ~st_q.prev & ~dir;
        st_d.raw  = (st_q.raw & ~(clr_en ? clr_bits : '0)) | rise;
        st_d.prev = pin_in;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign raw = st_q.raw;
    assign irq = |(st_q.raw & mask);

    // R10: a newly set status bit always belongs to a pin that was an input
    a_r10_no_edge_on_outputs: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((st_q.raw & ~$past(st_q.raw) & $past(dir)) == '0));

endmodule

// File: rtl/gpio_regblock.sv
module gpio_regblock
    import gpio_regblock_pkg::*;
#(
    parameter bit EXTENDED = 1'b0,
    parameter int PIN_W    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err,
    input  logic [PIN_W-1:0]  gpio_in,
    output logic [PIN_W-1:0]  gpio_out,
    output logic [PIN_W-1:0]  gpio_oe,
    output logic [PIN_W-1:0]  gpio_pull,
    output logic [PIN_W-1:0]  gpio_ana,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] RSV_LO = EXTENDED ? RSV_LO_EXT : RSV_LO_PLAIN;

    typedef struct packed {
        logic [PIN_W-1:0] data;
        logic [PIN_W-1:0] dir;
        logic [PIN_W-1:0] imask;
        logic [PIN_W-1:0] pull;
        logic [PIN_W-1:0] ana;
    } regs_t;

    regs_t             st_d, st_q;
    tgt_e              tgt;
    logic              bad;
    logic              wr_ok;
    logic              clr_en;
    logic [PIN_W-1:0]  amask;
    logic [PIN_W-1:0]  wbyte;
    logic [PIN_W-1:0]  pin_view;
    logic [PIN_W-1:0]  raw;
    logic [DATA_W-1:0] rd_word;
    logic              unused_wdata;

    assign unused_wdata = ^bus_wdata[DATA_W-1:PIN_W];

    gpio_regblock_decode #(.EXTENDED(EXTENDED)) u_decode (
        .addr (bus_addr),
        .wr   (bus_wr),
        .tgt  (tgt),
        .bad  (bad)
    );

    assign amask  = bus_addr[PIN_W+1:2];
    assign wbyte  = bus_wdata[PIN_W-1:0];
    assign wr_ok  = bus_sel && bus_wr && !bad;
    assign clr_en = wr_ok && (tgt == TGT_ICLR);

    always_comb begin
        st_d = st_q;
        if (wr_ok) begin
            case (tgt)
                TGT_DATA:  st_d.data  = (st_q.data & ~amask) | (wbyte & amask);
                TGT_DIR:   st_d.dir   = wbyte;
                TGT_IMASK: st_d.imask = wbyte;
                TGT_PULL:  st_d.pull  = wbyte;
                TGT_ANA:   st_d.ana   = wbyte;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    gpio_regblock_irq #(.PIN_W(PIN_W)) u_irq (
        .clk      (clk),
        .rst      (rst),
        .pin_in   (gpio_in),
        .dir      (st_q.dir),
        .mask     (st_q.imask),
        .clr_en   (clr_en),
        .clr_bits (wbyte),
        .raw      (raw),
        .irq      (irq)
    );

    assign pin_view = (st_q.dir & st_q.data) | (~st_q.dir & gpio_in);

    always_comb begin
        rd_word = '0;
        case (tgt)
            TGT_DATA:  rd_word = DATA_W'(pin_view & amask);
            TGT_DIR:   rd_word = DATA_W'(st_q.dir);
            TGT_IMASK: rd_word = DATA_W'(st_q.imask);
            TGT_RAW:   rd_word = DATA_W'(raw);
            TGT_MIS:   rd_word = DATA_W'(raw & st_q.imask);
            TGT_PULL:  rd_word = DATA_W'(st_q.pull);
            TGT_ANA:   rd_word = DATA_W'(st_q.ana);
            TGT_ID:    rd_word = DATA_W'(id_value(EXTENDED, bus_addr[5:2] - 4'd4));
            default:   rd_word = '0;
        endcase
    end

    assign bus_rdata = (bus_sel && !bus_wr && !bad) ? rd_word : '0;
    assign bus_err   = bus_sel && bad;
    assign gpio_out  = st_q.data;
    assign gpio_oe   = st_q.dir;

    if (EXTENDED) begin : g_ext
        assign gpio_pull = st_q.pull;
        assign gpio_ana  = st_q.ana;
    end else begin : g_plain
        assign gpio_pull = '0;
        assign gpio_ana  = '0;
    end

    // R6: any word in the reserved range is flagged
    a_r6_reserved_flags_err: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && {bus_addr[ADDR_W-1:2], 2'b00} >= RSV_LO
                 && {bus_addr[ADDR_W-1:2], 2'b00} <= RSV_HI) |-> bus_err);

    // R6: a flagged read returns zero
    a_r6_err_read_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && bus_err) |-> (bus_rdata == '0));

    // R6: a flagged write leaves all registers untouched
    a_r6_err_write_no_effect: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_err) |=> $stable(st_q));

    // R2: masked data write keeps unselected bits
    a_r2_masked_write_keeps_bits: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_addr < OFS_DIR)
        |=> (((st_q.data ^ $past(st_q.data)) & ~$past(amask)) == '0));

    // R8: error never without a selected access
    a_r8_err_only_when_selected: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> bus_sel);

    // R4: leaving reset, pins are inputs and the interrupt is quiet
    a_r4_reset_releases_clean: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (gpio_oe == '0 && !irq));

endmodule

// File: tb/gpio_regblock_tb_top.sv
module gpio_regblock_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [7:0]  gpio_in = '0;

    logic [1:0][31:0] rd_o;
    logic [1:0]       er_o, irq_o;
    logic [1:0][7:0]  out_o, oe_o, pull_o, ana_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_regblock #(.EXTENDED(1'b0)) dut_i (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(rd_o[0]), .bus_err(er_o[0]), .gpio_in(gpio_in),
        .gpio_out(out_o[0]), .gpio_oe(oe_o[0]), .gpio_pull(pull_o[0]),
        .gpio_ana(ana_o[0]), .irq(irq_o[0])
    );

    gpio_regblock #(.EXTENDED(1'b1)) dut_x (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(rd_o[1]), .bus_err(er_o[1]), .gpio_in(gpio_in),
        .gpio_out(out_o[1]), .gpio_oe(oe_o[1]), .gpio_pull(pull_o[1]),
        .gpio_ana(ana_o[1]), .irq(irq_o[1])
    );

    // ---------------- behavioural reference model ----------------
    logic [7:0] m_data[2], m_dir[2], m_mask[2], m_raw[2];
    logic [7:0] m_pull[2], m_ana[2], m_prev[2];

    // kind: 0 none, 1 data, 2 dir, 3 mask, 4 raw, 5 masked status,
    //       6 clear, 7 pull, 8 analog, 9 id
    function automatic void m_access(input int v, input logic [11:0] a, input logic wr,
                                     output logic [31:0] rd, output logic er, output int kind);
        int w;
        int lo;
        w = int'(a) & 32'hFFC;
        lo = (v == 1) ? 32'h52C : 32'h424;
        rd = 0;
        er = 1'b0;
        kind = 0;
        if (w < 32'h400) begin
            kind = 1;
            rd = {24'h0, ((m_dir[v] & m_data[v]) | (~m_dir[v] & gpio_in)) & a[9:2]};
        end else if (w >= lo && w <= 32'hFCC) begin
            kind = 0;
        end else if (w >= 32'hFD0) begin
            kind = 9;
            rd = ((v == 1) ? 32'h90 : 32'h60) + (w - 32'hFD0) / 4;
        end else if (w == 32'h400) begin kind = 2; rd = {24'h0, m_dir[v]};
        end else if (w == 32'h410) begin kind = 3; rd = {24'h0, m_mask[v]};
        end else if (w == 32'h414) begin kind = 4; rd = {24'h0, m_raw[v]};
        end else if (w == 32'h418) begin kind = 5; rd = {24'h0, m_raw[v] & m_mask[v]};
        end else if (w == 32'h41C) begin kind = 6; rd = 0;
        end else if (w == 32'h510 && v == 1) begin kind = 7; rd = {24'h0, m_pull[v]};
        end else if (w == 32'h528 && v == 1) begin kind = 8; rd = {24'h0, m_ana[v]};
        end
        if (kind == 0) er = 1'b1;
        if (wr && (kind == 4 || kind == 5 || kind == 9)) er = 1'b1;
        if (wr || er) rd = 0;
    endfunction

    always @(posedge clk) begin
        for (int v = 0; v < 2; v++) begin
            logic [31:0] rd;
            logic er;
            int kind;
            logic [7:0] rise;
            logic [7:0] wb;
            if (rst) begin
                m_data[v] = 0; m_dir[v] = 0; m_mask[v] = 0; m_raw[v] = 0;
                m_pull[v] = 0; m_ana[v] = 0; m_prev[v] = 0;
            end else begin
                m_access(v, bus_addr, bus_wr, rd, er, kind);
                wb = bus_wdata[7:0];
                rise = gpio_in & ~m_prev[v] & ~m_dir[v];
                m_prev[v] = gpio_in;
                if (bus_sel && bus_wr && !er && kind == 6) m_raw[v] = m_raw[v] & ~wb;
                m_raw[v] = m_raw[v] | rise;
                if (bus_sel && bus_wr && !er) begin
                    case (kind)
                        1: m_data[v] = (m_data[v] & ~bus_addr[9:2]) | (wb & bus_addr[9:2]);
                        2: m_dir[v] = wb;
                        3: m_mask[v] = wb;
                        7: m_pull[v] = wb;
                        8: m_ana[v] = wb;
                        default: ;
                    endcase
                end
            end
        end
    end

    task automatic chk(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic string rd_tag(input logic [11:0] a);
        if (a < 12'h400) return "R1";
        if (a >= 12'hFD0) return "R9";
        return "R6";
    endfunction

    // per-cycle comparison of both variants against the model
    always @(negedge clk) begin
        if (!rst) begin
            for (int v = 0; v < 2; v++) begin
                logic [31:0] rd;
                logic er;
                int kind;
                m_access(v, bus_addr, bus_wr, rd, er, kind);
                if (!bus_sel) begin rd = 0; er = 1'b0; end
                chk(rd_tag(bus_addr), "rdata", rd_o[v], rd);
                chk("R8", "err", {31'h0, er_o[v]}, {31'h0, er});
                chk("R2", "gpio_out", {24'h0, out_o[v]}, {24'h0, m_data[v]});
                chk("R3", "gpio_oe", {24'h0, oe_o[v]}, {24'h0, m_dir[v]});
                chk("R5", "gpio_pull", {24'h0, pull_o[v]}, (v == 1) ? {24'h0, m_pull[v]} : 32'h0);
                chk("R5", "gpio_ana", {24'h0, ana_o[v]}, (v == 1) ? {24'h0, m_ana[v]} : 32'h0);
                chk("R10", "irq", {31'h0, irq_o[v]}, {31'h0, |(m_raw[v] & m_mask[v])});
            end
        end
    end

    // ---------------- stimulus ----------------
    // caller sits at a falling edge; access stays on the bus for one cycle
    task automatic access(input logic wr, input logic [11:0] a, input logic [31:0] d);
        #1;
        bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
        @(negedge clk);
    endtask

    task automatic idle();
        #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        for (int v = 0; v < 2; v++) begin
            chk("R4", "reset out", {24'h0, out_o[v]}, 0);
            chk("R4", "reset oe", {24'h0, oe_o[v]}, 0);
            chk("R4", "reset pull/ana", {16'h0, pull_o[v], ana_o[v]}, 0);
            chk("R4", "reset irq", {31'h0, irq_o[v]}, 0);
        end
        access(1'b0, 12'h400, 0);
        chk("R4", "dir reads zero", rd_o[1], 0);

        access(1'b1, 12'h400, 32'hFFF0_0F0F);
        chk("R3", "oe after dir write", {24'h0, oe_o[0]}, 32'h0F);
        access(1'b1, 12'h3FC, 32'h0000_00A5);
        chk("R2", "full-mask write", {24'h0, out_o[1]}, 32'hA5);
        access(1'b1, 12'h00C, 32'h0000_005A);
        chk("R2", "partial-mask write", {24'h0, out_o[0]}, 32'hA6);

        #1 gpio_in = 8'h30;
        idle();
        access(1'b0, 12'h3FC, 0);
        chk("R1", "full-mask read", rd_o[0], 32'h36);
        chk("R8", "no err on valid", {31'h0, er_o[0]}, 0);
        access(1'b0, 12'h0C0, 0);
        chk("R1", "input-bit read", rd_o[1], 32'h30);
        access(1'b0, 12'h014, 0);
        chk("R1", "sparse-mask read", rd_o[0], 32'h04);

        access(1'b1, 12'h410, 32'h10);
        chk("R10", "irq after mask", {31'h0, irq_o[0]}, 1);
        access(1'b0, 12'h418, 0);
        chk("R10", "masked status", rd_o[1], 32'h10);
        access(1'b1, 12'h41C, 32'h10);
        chk("R10", "irq after clear", {31'h0, irq_o[1]}, 0);
        access(1'b0, 12'h414, 0);
        chk("R10", "raw after clear", rd_o[0], 32'h20);

        access(1'b1, 12'h528, 32'h1C3);
        chk("R5", "analog ext", {24'h0, ana_o[1]}, 32'hC3);
        chk("R5", "analog plain", {24'h0, ana_o[0]}, 0);
        chk("R6", "plain 0x528 err", {31'h0, er_o[0]}, 1);
        access(1'b1, 12'h510, 32'h77);
        chk("R5", "pull ext", {24'h0, pull_o[1]}, 32'h77);
        chk("R6", "plain 0x510 err", {31'h0, er_o[0]}, 1);
        access(1'b0, 12'h528, 0);
        chk("R5", "analog readback", rd_o[1], 32'hC3);
        chk("R6", "plain reserved reads zero", rd_o[0], 0);

        access(1'b0, 12'h424, 0);
        chk("R6", "plain start err", {31'h0, er_o[0]}, 1);
        chk("R7", "ext gap err", {31'h0, er_o[1]}, 1);
        access(1'b0, 12'h52C, 0);
        chk("R6", "ext start err", {31'h0, er_o[1]}, 1);
        chk("R6", "ext start zero", rd_o[1], 0);
        access(1'b0, 12'hFCC, 0);
        chk("R6", "end err", {30'h0, er_o}, 32'h3);
        access(1'b1, 12'h424, 32'hFF);
        access(1'b0, 12'h400, 0);
        chk("R6", "dir kept", rd_o[0], 32'h0F);
        access(1'b1, 12'h520, 32'hFF);
        chk("R7", "ext gap write err", {31'h0, er_o[1]}, 1);
        access(1'b0, 12'h404, 0);
        chk("R7", "gap read err", {30'h0, er_o}, 32'h3);
        access(1'b1, 12'h414, 32'hFF);
        chk("R7", "raw write err", {30'h0, er_o}, 32'h3);

        access(1'b0, 12'hFD0, 0);
        chk("R9", "id0 plain", rd_o[0], 32'h60);
        chk("R9", "id0 ext", rd_o[1], 32'h90);
        access(1'b0, 12'hFFC, 0);
        chk("R9", "id11 plain", rd_o[0], 32'h6B);
        chk("R9", "id11 ext", rd_o[1], 32'h9B);
        access(1'b1, 12'hFE0, 0);
        chk("R9", "id write err", {30'h0, er_o}, 32'h3);
        idle();
        chk("R8", "err dropped", {30'h0, er_o}, 0);

        for (int i = 0; i < 400; i++) begin
            logic [11:0] a;
            int pick;
            pick = int'($urandom % 10);
            case (pick)
                0: a = 12'h400;
                1: a = 12'h410;
                2: a = 12'h414;
                3: a = 12'h418;
                4: a = 12'h41C;
                5: a = 12'h510;
                6: a = 12'h528;
                7: a = 12'($urandom);
                default: a = {2'b00, 10'($urandom)};
            endcase
            if (i % 7 == 0) gpio_in = 8'($urandom);
            if (i % 5 == 4) idle();
            else access(1'($urandom), a, $urandom);
        end
        idle();

        done = 1'b1;
        summary();
        $finish;
    end

endmodule